// File: doc/BRIEF.md
# Wake Source Qualifier and Attribution

This block sits between the raw wake inputs of a low-power controller and its mode sequencer. It watches four request lines: a digital bus-activity request, a local switch pin, a periodic timer tick and an ignition sense line. It decides which requests count as real wakes and reports that decision as a single qualified wake pulse. A request must come from an enabled source and survive a debounce (pin-type sources only). It must not arrive in the quiet window that follows low-power entry, in the cooldown after the previous wake, or once the storm cap for the current long window is used up.

The first accepted wake is classified and frozen in a reason register together with the policy identifier in force at that moment. An interrupt line stays high until software acknowledges. Later accepted wakes only set a sticky "additional wake" flag, so the original cause is never overwritten before it has been read. Two saturating counters report accepted wakes and rejected requests for diagnostics.

All inputs are expected to be synchronous to `clk`. Timing windows are counted in clock cycles and set by parameters.

Top module: `wake_qualifier`

## Requirements
- R1: After a synchronous reset, `wake_reason` is 0, `irq`, `wake_pulse` and `extra_wake` are low, and both counters read 0.
- R2: The bus and timer sources raise a candidate on the rising edge of their request. Reason codes are 1 = timer, 2 = local, 3 = bus, 4 = ignition, and 0 = nothing latched.
- R3: A local or ignition request becomes a candidate in the DEB_CYC-th consecutive cycle it is high. A shorter high period produces no wake and no counter change.
- R4: `src_en` bit 0 enables timer, bit 1 local, bit 2 bus and bit 3 ignition. A candidate from a disabled source produces no wake and leaves the reason at 0.
- R5: When several enabled candidates are accepted in one cycle, the latched reason follows ignition > bus > local > timer, and `extra_wake` is set.
- R6: A cycle with `lp_entry` high starts a blanking window. Candidates in the following BLANK_CYC cycles are rejected, and one that arrives BLANK_CYC+2 cycles after entry is accepted.
- R7: After an accepted wake, candidates in the next COOL_CYC cycles are rejected, and a candidate after that is accepted.
- R8: At most STORM_CAP wakes are accepted per STORM_WIN-cycle window, counted from reset. Further candidates in that window are rejected, and acceptance resumes in the next window.
- R9: Each accepted wake gives a `wake_pulse` exactly one cycle wide, in the cycle after acceptance. It also increments the saturating `wake_count`.
- R10: The reason and `reason_policy` (the `policy_id` at acceptance) are frozen while a reason is pending. A further accepted wake only sets `extra_wake` and increments the count. `irq` is high exactly while a reason is pending, and `ack` clears reason, flag and `irq`.
- R11: `blocked_count` increments by one in every cycle in which at least one candidate is rejected, whether masked, blanked, cooling down or capped. It saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_entry | input | 1 | One-cycle strobe: low-power mode entered |
| src_en | input | 4 | Source enable mask (timer, local, bus, ignition) |
| policy_id | input | PID_W | Identifier of the active wake policy |
| ack | input | 1 | Software acknowledge of the latched reason |
| bus_wake | input | 1 | Decoded bus-activity wake request |
| local_wake | input | 1 | Local pin wake request |
| timer_wake | input | 1 | Periodic timer wake request |
| ign_wake | input | 1 | Ignition sense wake request |
| wake_pulse | output | 1 | One-cycle qualified wake to the mode sequencer |
| irq | output | 1 | Interrupt, high while a reason is pending |
| wake_reason | output | 3 | Latched reason code |
| extra_wake | output | 1 | Sticky: another wake accepted while pending |
| reason_policy | output | PID_W | Policy identifier captured with the reason |
| wake_count | output | CNT_W | Saturating count of accepted wakes |
| blocked_count | output | CNT_W | Saturating count of cycles with rejected candidates |

## Verification
The main function is driven with single-source requests of each kind, simultaneous pairs and the full set of four, and pin requests held one cycle short of and exactly at the debounce length. Each pattern is applied with a full mask and with selected sources masked. Single sources separate the four reason codes. Simultaneous requests reveal the priority order and the extra flag. The mixed all-source case shows the debounced sources arriving late and falling into cooldown. Directed runs place requests one cycle inside and just outside the blanking and cooldown windows, exceed the storm cap and then cross into the next window, and drive the rejection counter into saturation.

// File: rtl/wake_qual_pkg.sv
package wake_qual_pkg;
  localparam int NSRC    = 4;
  localparam int SRC_TMR = 0;
  localparam int SRC_LOC = 1;
  localparam int SRC_BUS = 2;
  localparam int SRC_IGN = 3;

  typedef enum logic [2:0] {
    WR_NONE  = 3'd0,
    WR_TIMER = 3'd1,
    WR_LOCAL = 3'd2,
    WR_BUS   = 3'd3,
    WR_IGN   = 3'd4
  } wake_reason_e;
endpackage

// File: rtl/wake_src_filter.sv
module wake_src_filter #(
  parameter int DEB_CYC = 0  // 0: edge-triggered source, >0: debounced level source
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic cand
);
  generate
    if (DEB_CYC == 0) begin : g_edge
      logic req_d;
      always_ff @(posedge clk) begin
        if (rst) req_d <= 1'b0;
        else     req_d <= req;
      end
      assign cand = req & ~req_d;
    end else begin : g_deb
      localparam int CW = $clog2(DEB_CYC + 2);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst)                      cnt <= '0;
        else if (!req)                cnt <= '0;
        else if (cnt != CW'(DEB_CYC)) cnt <= cnt + 1'b1;
      end
      // fires once, in the DEB_CYC-th consecutive high cycle
      assign cand = req && (cnt == CW'(DEB_CYC - 1));
    end
  endgenerate
endmodule

// File: rtl/wake_gate.sv
module wake_gate #(
  parameter int BLANK_CYC = 64,
  parameter int COOL_CYC  = 32,
  parameter int STORM_CAP = 8,
  parameter int STORM_WIN = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic lp_entry,
  input  logic accept,
  output logic open
);
  localparam int BW = $clog2(BLANK_CYC + 2);
  localparam int KW = $clog2(COOL_CYC + 2);
  localparam int TW = $clog2(STORM_WIN + 1);
  localparam int AW = $clog2(STORM_CAP + 2);

  logic [BW-1:0] blank_cnt;
  logic [KW-1:0] cool_cnt;
  logic [TW-1:0] win_t;
  logic [AW-1:0] win_acc;
  logic          win_end;

  assign win_end = (win_t == TW'(STORM_WIN - 1));
  assign open    = (blank_cnt == '0) && (cool_cnt == '0) && (win_acc != AW'(STORM_CAP));

  always_ff @(posedge clk) begin
    if (rst) begin
      blank_cnt <= '0;
      cool_cnt  <= '0;
      win_t     <= '0;
      win_acc   <= '0;
    end else begin
      if (lp_entry)              blank_cnt <= BW'(BLANK_CYC);
      else if (blank_cnt != '0)  blank_cnt <= blank_cnt - 1'b1;

      if (accept)                cool_cnt <= KW'(COOL_CYC);
      else if (cool_cnt != '0)   cool_cnt <= cool_cnt - 1'b1;

      win_t <= win_end ? '0 : win_t + 1'b1;
      if (win_end)     win_acc <= accept ? AW'(1) : '0;
      else if (accept) win_acc <= win_acc + 1'b1;
    end
  end

  // R6
  blank_block_chk: assert property (@(posedge clk) disable iff (rst)
    (lp_entry && BLANK_CYC > 0) |=> !open);
  // R7
  cool_block_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && COOL_CYC > 0) |=> !open);
  // R8
  cap_limit_chk: assert property (@(posedge clk) disable iff (rst)
    win_acc <= AW'(STORM_CAP));
endmodule

// File: rtl/wake_latch.sv
module wake_latch
  import wake_qual_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PID_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  ok_vec,
  input  logic             masked_any,
  input  logic             gate_open,
  input  logic             ack,
  input  logic [PID_W-1:0] policy_in,
  output logic             accept,
  output logic             wake_pulse,
  output logic             irq,
  output logic [2:0]       reason,
  output logic             extra,
  output logic [PID_W-1:0] policy_q,
  output logic [CNT_W-1:0] wake_cnt,
  output logic [CNT_W-1:0] blk_cnt
);
  wake_reason_e reason_q, top_r;
  logic         rejected, multiple;

  assign accept   = gate_open && (|ok_vec);
  assign rejected = masked_any || ((|ok_vec) && !gate_open);
  assign multiple = ($countones(ok_vec) > 1);
  assign reason   = reason_q;

  always_comb begin
    top_r = WR_NONE;
    if      (ok_vec[SRC_IGN]) top_r = WR_IGN;
    else if (ok_vec[SRC_BUS]) top_r = WR_BUS;
    else if (ok_vec[SRC_LOC]) top_r = WR_LOCAL;
    else if (ok_vec[SRC_TMR]) top_r = WR_TIMER;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reason_q   <= WR_NONE;
      extra      <= 1'b0;
      irq        <= 1'b0;
      policy_q   <= '0;
      wake_pulse <= 1'b0;
      wake_cnt   <= '0;
      blk_cnt    <= '0;
    end else begin
      wake_pulse <= accept;
      if (accept) begin
        if (reason_q == WR_NONE || ack) begin
          reason_q <= top_r;
          policy_q <= policy_in;
          extra    <= multiple;
          irq      <= 1'b1;
        end else begin
          extra <= 1'b1;
        end
      end else if (ack) begin
        reason_q <= WR_NONE;
        extra    <= 1'b0;
        irq      <= 1'b0;
      end
      if (accept && wake_cnt != '1)  wake_cnt <= wake_cnt + 1'b1;
      if (rejected && blk_cnt != '1) blk_cnt  <= blk_cnt + 1'b1;
    end
  end

  // R10
  reason_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (reason_q != WR_NONE && !ack) |=> ($stable(reason_q) && $stable(policy_q)));
  // R10
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (reason_q != WR_NONE));
  // R11
  blk_mono_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (blk_cnt >= $past(blk_cnt)));
endmodule

// File: rtl/wake_qualifier.sv
module wake_qualifier
  import wake_qual_pkg::*;
#(
  parameter int DEB_CYC   = 16,
  parameter int BLANK_CYC = 64,
  parameter int COOL_CYC  = 32,
  parameter int STORM_CAP = 8,
  parameter int STORM_WIN = 100000,
  parameter int CNT_W     = 8,
  parameter int PID_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lp_entry,
  input  logic [3:0]       src_en,
  input  logic [PID_W-1:0] policy_id,
  input  logic             ack,
  input  logic             bus_wake,
  input  logic             local_wake,
  input  logic             timer_wake,
  input  logic             ign_wake,
  output logic             wake_pulse,
  output logic             irq,
  output logic [2:0]       wake_reason,
  output logic             extra_wake,
  output logic [PID_W-1:0] reason_policy,
  output logic [CNT_W-1:0] wake_count,
  output logic [CNT_W-1:0] blocked_count
);
  logic [NSRC-1:0] raw, cand, ok_vec;
  logic            gate_open, accept;

  assign raw = {ign_wake, bus_wake, local_wake, timer_wake};

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      localparam int D = (i == SRC_LOC || i == SRC_IGN) ? DEB_CYC : 0;
      wake_src_filter #(.DEB_CYC(D)) u_filt (
        .clk (clk),
        .rst (rst),
        .req (raw[i]),
        .cand(cand[i])
      );
    end
  endgenerate

  assign ok_vec = cand & src_en;

  wake_gate #(
    .BLANK_CYC(BLANK_CYC), .COOL_CYC(COOL_CYC),
    .STORM_CAP(STORM_CAP), .STORM_WIN(STORM_WIN)
  ) u_gate (
    .clk     (clk),
    .rst     (rst),
    .lp_entry(lp_entry),
    .accept  (accept),
    .open    (gate_open)
  );

  wake_latch #(.CNT_W(CNT_W), .PID_W(PID_W)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .ok_vec    (ok_vec),
    .masked_any(|(cand & ~src_en)),
    .gate_open (gate_open),
    .ack       (ack),
    .policy_in (policy_id),
    .accept    (accept),
    .wake_pulse(wake_pulse),
    .irq       (irq),
    .reason    (wake_reason),
    .extra     (extra_wake),
    .policy_q  (reason_policy),
    .wake_cnt  (wake_count),
    .blk_cnt   (blocked_count)
  );

  generate
    if (COOL_CYC > 0) begin : g_pulse_chk
      // R9
      pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);
    end
  endgenerate
endmodule

// File: tb/test_wake_qualifier.sv
`timescale 1ns/1ps
module test_wake_qualifier;
  localparam int DEB = 4, BLANK = 10, COOL = 6, CAP = 3, WIN = 64, CW = 4, PW = 4;

  logic clk = 1'b0;
  logic rst, lp_entry, ack, bus, loc, tmr, ign;
  logic [3:0] en;
  logic [PW-1:0] pol;
  logic wake_pulse, irq, extra;
  logic [2:0] reason;
  logic [PW-1:0] rpol;
  logic [CW-1:0] wcnt, bcnt;
  int nchk = 0, nerr = 0;

  always #2.5 clk = ~clk;

  wake_qualifier #(
    .DEB_CYC(DEB), .BLANK_CYC(BLANK), .COOL_CYC(COOL), .STORM_CAP(CAP),
    .STORM_WIN(WIN), .CNT_W(CW), .PID_W(PW)
  ) i_wake_qualifier (
    .clk(clk), .rst(rst), .lp_entry(lp_entry), .src_en(en), .policy_id(pol), .ack(ack),
    .bus_wake(bus), .local_wake(loc), .timer_wake(tmr), .ign_wake(ign),
    .wake_pulse(wake_pulse), .irq(irq), .wake_reason(reason), .extra_wake(extra),
    .reason_policy(rpol), .wake_count(wcnt), .blocked_count(bcnt)
  );

  // {en, req{ign,bus,loc,tmr}, hold, reason, extra, blocked, count}
  localparam logic [23:0] VEC [12] = '{
    {4'hF, 4'b0100, 4'd1, 3'd3, 1'b0, 4'd0, 4'd1},  // R2 bus
    {4'hF, 4'b0001, 4'd1, 3'd1, 1'b0, 4'd0, 4'd1},  // R2 timer
    {4'hF, 4'b0010, 4'd4, 3'd2, 1'b0, 4'd0, 4'd1},  // R3 local full debounce
    {4'hF, 4'b0010, 4'd3, 3'd0, 1'b0, 4'd0, 4'd0},  // R3 local too short
    {4'hF, 4'b1000, 4'd4, 3'd4, 1'b0, 4'd0, 4'd1},  // R3 ignition full debounce
    {4'hF, 4'b1000, 4'd2, 3'd0, 1'b0, 4'd0, 4'd0},  // R3 ignition too short
    {4'hF, 4'b1111, 4'd4, 3'd3, 1'b1, 4'd1, 4'd1},  // R5 all: bus first, pins fall in cooldown
    {4'hF, 4'b0101, 4'd1, 3'd3, 1'b1, 4'd0, 4'd1},  // R5 bus over timer
    {4'hB, 4'b0101, 4'd1, 3'd1, 1'b0, 4'd1, 4'd1},  // R4 bus masked, timer taken
    {4'h0, 4'b0100, 4'd1, 3'd0, 1'b0, 4'd1, 4'd0},  // R4 all masked
    {4'h7, 4'b1000, 4'd4, 3'd0, 1'b0, 4'd1, 4'd0},  // R4 ignition masked
    {4'hF, 4'b1010, 4'd4, 3'd4, 1'b1, 4'd0, 4'd1}   // R5 ignition over local
  };

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; lp_entry = 0; ack = 0; bus = 0; loc = 0; tmr = 0; ign = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic bus_pulse();
    @(negedge clk) bus = 1;
    @(negedge clk) bus = 0;
  endtask

  initial begin
    #(200_000 * 5);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    en = 4'hF; pol = 4'd2;
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk("R1 reason", reason, 0);
    chk("R1 irq", irq, 0);
    chk("R1 pulse", wake_pulse, 0);
    chk("R1 extra", extra, 0);
    chk("R1 wcnt", wcnt, 0);
    chk("R1 bcnt", bcnt, 0);

    for (int v = 0; v < 12; v++) begin
      do_reset();
      @(negedge clk);
      en  = VEC[v][23:20];
      {ign, bus, loc, tmr} = VEC[v][19:16];
      repeat (VEC[v][15:12]) @(negedge clk);
      {ign, bus, loc, tmr} = 4'b0;
      repeat (3) @(negedge clk);
      chk($sformatf("R2/R3/R4/R5 vec%0d reason", v), reason, VEC[v][11:9]);
      chk($sformatf("R5 vec%0d extra", v), extra, VEC[v][8]);
      chk($sformatf("R11 vec%0d blocked", v), bcnt, VEC[v][7:4]);
      chk($sformatf("R9 vec%0d count", v), wcnt, VEC[v][3:0]);
      chk($sformatf("R10 vec%0d irq", v), irq, (VEC[v][11:9] != 0) ? 1 : 0);
    end

    // R9 / R10: pulse width, frozen reason, policy capture, ack
    en = 4'hF; pol = 4'd5;
    do_reset();
    @(negedge clk) bus = 1;
    @(posedge clk) #1;
    chk("R9 pulse high", wake_pulse, 1);
    chk("R10 irq set", irq, 1);
    @(negedge clk) begin bus = 0; pol = 4'd9; end
    @(posedge clk) #1;
    chk("R9 pulse one cycle", wake_pulse, 0);
    repeat (COOL + 2) @(negedge clk);
    loc = 1;
    repeat (DEB) @(negedge clk);
    loc = 0;
    repeat (2) @(negedge clk);
    chk("R10 reason frozen", reason, 3);
    chk("R10 extra set", extra, 1);
    chk("R10 policy frozen", rpol, 5);
    chk("R9 count two", wcnt, 2);
    @(negedge clk) ack = 1;
    @(negedge clk) ack = 0;
    chk("R10 ack reason", reason, 0);
    chk("R10 ack irq", irq, 0);
    chk("R10 ack extra", extra, 0);

    // R7 cooldown boundary
    do_reset();
    @(negedge clk) bus = 1;
    @(negedge clk) bus = 0;
    repeat (COOL - 1) @(negedge clk);
    bus = 1;                       // sampled COOL cycles after acceptance
    @(negedge clk) bus = 0;
    @(negedge clk) bus = 1;        // COOL+2 cycles after
    @(negedge clk) bus = 0;
    repeat (2) @(negedge clk);
    chk("R7 cooldown blocked", bcnt, 1);
    chk("R7 after cooldown accepted", wcnt, 2);

    // R6 blanking boundary
    do_reset();
    @(negedge clk) lp_entry = 1;
    @(negedge clk) lp_entry = 0;
    repeat (BLANK - 1) @(negedge clk);
    bus = 1;                       // last blanked cycle
    @(negedge clk) bus = 0;
    @(negedge clk) bus = 1;        // BLANK+2 after entry
    @(negedge clk) bus = 0;
    repeat (2) @(negedge clk);
    chk("R6 blanked", bcnt, 1);
    chk("R6 after blank accepted", wcnt, 1);
    chk("R6 reason", reason, 3);

    // R8 storm cap and window rollover
    do_reset();
    for (int p = 0; p < CAP + 1; p++) begin
      bus_pulse();
      repeat (8) @(negedge clk);
    end
    chk("R8 capped count", wcnt, CAP);
    chk("R8 capped blocked", bcnt, 1);
    repeat (WIN + 6) @(negedge clk);
    bus_pulse();
    repeat (2) @(negedge clk);
    chk("R8 next window accepted", wcnt, CAP + 1);

    // R11 saturation with everything masked (R4)
    do_reset();
    en = 4'h0;
    for (int p = 0; p < 20; p++) bus_pulse();
    repeat (2) @(negedge clk);
    chk("R11 blocked saturates", bcnt, 15);
    chk("R4 masked no wake", wcnt, 0);
    chk("R4 masked no reason", reason, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule